// File: doc/BRIEF.md
# Automatic RTS/CTS Flow Controller

This block runs the hardware handshake of one UART channel. On the receive side it compares the fill level of the receive FIFO with a programmed trigger level. When the FIFO reaches the trigger, the block drives the active-low request-to-send output high so the far end stops sending. It drives the output low again only after the level has fallen by a selectable hysteresis margin. A flow-control interrupt flag is high while the receive FIFO sits at or above the trigger with automatic RTS enabled.

On the transmit side the active-low clear-to-send input passes through a two-flop synchronizer. When automatic CTS is enabled and the far end drives CTS high, the block raises a transmit-hold signal for the transmitter state machine. If a character is on the line, the hold waits for that character's stop-bit strobe, so a character is never cut short. If the transmitter is idle, the hold takes effect at once, before any new start bit. The hold drops as soon as the synchronized CTS returns low. The transmitter must not begin a character while the hold is high.

Top module: `uart_autoflow`

## Requirements
- R1: After reset, rts_n is 1, tx_hold is 0 and fc_irq is 0.
- R2: While rts_auto_en is 0, rts_n is 1 and fc_irq is 0 one cycle later, whatever the FIFO level.
- R3: With rts_auto_en at 1, a rx_level at or above rx_trigger sets rts_n to 1 on the next clock edge.
- R4: fc_irq is 1 one cycle after any cycle in which rts_auto_en is 1 and rx_level is at or above rx_trigger, and is 0 otherwise.
- R5: hyst_sel codes 0, 1, 2 and 3 give margins of 0, 4, 6 and 8 entries. rts_n goes to 0 one cycle after rx_level is at or below rx_trigger minus the margin (clamped at zero). Between that mark and the trigger, rts_n keeps its value.
- R6: cts_n is synchronized through two flops, so tx_hold responds on the third clock edge after a change of cts_n.
- R7: When synchronized CTS is high while tx_busy is 1, tx_hold stays 0 until a cycle with tx_char_done at 1. It rises on the edge after that cycle.
- R8: When synchronized CTS is high while tx_busy is 0, tx_hold rises on the next edge.
- R9: When synchronized CTS is low, tx_hold is 0 on the next edge.
- R10: While cts_auto_en is 0, tx_hold is 0 one cycle later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rts_auto_en | input | 1 | Enables automatic RTS |
| cts_auto_en | input | 1 | Enables automatic CTS |
| rx_level | input | 7 | Receive FIFO fill level (0 to 64) |
| rx_trigger | input | 7 | Receive trigger level |
| hyst_sel | input | 2 | Hysteresis code |
| cts_n | input | 1 | Clear-to-send from the line, active low, asynchronous |
| tx_busy | input | 1 | Transmitter is sending a character |
| tx_char_done | input | 1 | Strobe: stop bit of the current character completes |
| rts_n | output | 1 | Request-to-send to the line, active low |
| tx_hold | output | 1 | Transmitter must not start a new character |
| fc_irq | output | 1 | Flow-control interrupt flag |

## Verification
The hardest case to reach is a CTS stop that arrives while a character is on the line. Because of the synchronizer delay, the bench holds tx_busy high across the whole latency window and for several more cycles. It confirms that tx_hold stays low throughout, then pulses tx_char_done and expects the hold on the following edge. The hysteresis band is reached by first driving the level over the trigger. The level is then walked down to one entry above the release mark, and then onto the mark itself. The code-3 case uses a trigger below the margin to exercise the clamp at zero.

// File: rtl/uart_autoflow.sv
module uart_autoflow #(
  parameter int DEPTH = 64,
  parameter int HYST1 = 4,
  parameter int HYST2 = 6,
  parameter int HYST3 = 8,
  localparam int LW = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          rts_auto_en,
  input  logic          cts_auto_en,
  input  logic [LW-1:0] rx_level,
  input  logic [LW-1:0] rx_trigger,
  input  logic [1:0]    hyst_sel,
  input  logic          cts_n,
  input  logic          tx_busy,
  input  logic          tx_char_done,
  output logic          rts_n,
  output logic          tx_hold,
  output logic          fc_irq
);

  logic [LW-1:0] margin, low_mark;
  logic          at_trig;
  logic          cts_m, cts_s;

  always_comb begin
    case (hyst_sel)
      2'd1:    margin = LW'(HYST1);
      2'd2:    margin = LW'(HYST2);
      2'd3:    margin = LW'(HYST3);
      default: margin = '0;
    endcase
  end

  assign low_mark = (rx_trigger > margin) ? rx_trigger - margin : '0;
  assign at_trig  = rx_level >= rx_trigger;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rts_n  <= 1'b1;
      fc_irq <= 1'b0;
    end else begin
      fc_irq <= rts_auto_en && at_trig;
      if (!rts_auto_en || at_trig) rts_n <= 1'b1;
      else if (rx_level <= low_mark) rts_n <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cts_m   <= 1'b0;
      cts_s   <= 1'b0;
      tx_hold <= 1'b0;
    end else begin
      cts_m <= cts_n;
      cts_s <= cts_m;
      if (!cts_auto_en || !cts_s) tx_hold <= 1'b0;
      else if (!tx_busy || tx_char_done) tx_hold <= 1'b1;
    end
  end

  a_r2_auto_off: assert property (@(posedge clk) disable iff (!rst_n)
    !rts_auto_en |=> (rts_n && !fc_irq));
  a_r3_stop_at_trigger: assert property (@(posedge clk) disable iff (!rst_n)
    (rts_auto_en && at_trig) |=> rts_n);
  a_r4_irq_implies_stop: assert property (@(posedge clk) disable iff (!rst_n)
    fc_irq |-> rts_n);
  a_r5_release_at_mark: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(rts_n) |-> $past(rx_level <= low_mark));
  a_r7_hold_on_boundary: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(tx_hold) |-> $past(!tx_busy || tx_char_done));
  a_r10_cts_off: assert property (@(posedge clk) disable iff (!rst_n)
    !cts_auto_en |=> !tx_hold);

endmodule

// File: tb/uart_autoflow_tb_top.sv
module uart_autoflow_tb_top;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic rts_auto_en = 1'b0, cts_auto_en = 1'b0;
  logic [6:0] rx_level = '0, rx_trigger = '0;
  logic [1:0] hyst_sel = '0;
  logic cts_n = 1'b0, tx_busy = 1'b0, tx_char_done = 1'b0;
  logic rts_n, tx_hold, fc_irq;

  int checks = 0, errors = 0;
  bit done = 0;

  typedef struct { logic rts; logic hold; logic irq; string tag; } item_t;
  item_t q[$];

  logic m_rts = 1'b1, m_hold = 1'b0, m_irq = 1'b0, m_s1 = 1'b0, m_s2 = 1'b0;

  uart_autoflow dut_i (
    .clk(clk), .rst_n(rst_n), .rts_auto_en(rts_auto_en), .cts_auto_en(cts_auto_en),
    .rx_level(rx_level), .rx_trigger(rx_trigger), .hyst_sel(hyst_sel), .cts_n(cts_n),
    .tx_busy(tx_busy), .tx_char_done(tx_char_done),
    .rts_n(rts_n), .tx_hold(tx_hold), .fc_irq(fc_irq));

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic compare(item_t e);
    checks++;
    if (rts_n !== e.rts || tx_hold !== e.hold || fc_irq !== e.irq) begin
      errors++;
      $display("FAIL %s: actual rts_n=%b hold=%b irq=%b expected rts_n=%b hold=%b irq=%b",
               e.tag, rts_n, tx_hold, fc_irq, e.rts, e.hold, e.irq);
    end
  endtask

  task automatic tick(string tag);
    int h, lowm;
    item_t e;
    h = (hyst_sel == 2'd1) ? 4 : (hyst_sel == 2'd2) ? 6 : (hyst_sel == 2'd3) ? 8 : 0;
    lowm = (int'(rx_trigger) > h) ? int'(rx_trigger) - h : 0;
    m_irq = rts_auto_en && (rx_level >= rx_trigger);
    if (!rts_auto_en || rx_level >= rx_trigger) m_rts = 1'b1;
    else if (int'(rx_level) <= lowm) m_rts = 1'b0;
    if (!cts_auto_en || !m_s2) m_hold = 1'b0;
    else if (!tx_busy || tx_char_done) m_hold = 1'b1;
    m_s2 = m_s1;
    m_s1 = cts_n;
    e.rts = m_rts; e.hold = m_hold; e.irq = m_irq; e.tag = tag;
    q.push_back(e);
    @(posedge clk);
    @(negedge clk);
  endtask

  initial begin : monitor
    forever begin
      @(posedge clk);
      #1;
      if (q.size() > 0) compare(q.pop_front());
    end
  end

  initial begin : watchdog
    #(CLK_PERIOD * 200000);
    errors++;
    checks++;
    $display("FAIL watchdog: actual timeout expected completion");
    done = 1;
  end

  initial begin : driver
    item_t r;
    repeat (3) @(negedge clk);
    r.rts = 1'b1; r.hold = 1'b0; r.irq = 1'b0; r.tag = "R1 reset";
    compare(r);
    rst_n = 1'b1;
    @(negedge clk);

    rx_trigger = 7'd32; rx_level = 7'd50;
    repeat (3) tick("R2 auto rts off");

    rts_auto_en = 1'b1; hyst_sel = 2'd0; rx_level = 7'd0;
    tick("R5 code0 release");
    rx_level = 7'd32; tick("R3 R4 at trigger");
    rx_level = 7'd31; tick("R5 code0 just below");

    hyst_sel = 2'd2; rx_level = 7'd40; tick("R3 R4 over trigger");
    rx_level = 7'd27; tick("R5 code2 inside band");
    rx_level = 7'd26; tick("R5 code2 at mark");

    hyst_sel = 2'd1; rx_trigger = 7'd16; rx_level = 7'd16; tick("R3 code1 stop");
    rx_level = 7'd13; tick("R5 code1 inside band");
    rx_level = 7'd12; tick("R5 code1 at mark");

    hyst_sel = 2'd3; rx_trigger = 7'd5; rx_level = 7'd5; tick("R3 code3 stop");
    rx_level = 7'd1; tick("R5 code3 clamp band");
    rx_level = 7'd0; tick("R5 code3 clamp zero");
    rts_auto_en = 1'b0; tick("R2 disable after release");

    cts_auto_en = 1'b1; tx_busy = 1'b0; cts_n = 1'b1;
    tick("R6 sync stage1"); tick("R6 sync stage2"); tick("R6 R8 idle hold");
    cts_n = 1'b0;
    tick("R6 release pipe1"); tick("R6 release pipe2"); tick("R9 release");

    tx_busy = 1'b1; cts_n = 1'b1;
    repeat (6) tick("R7 hold deferred mid char");
    tx_char_done = 1'b1; tick("R7 hold at stop bit");
    tx_char_done = 1'b0; tx_busy = 1'b0; tick("R8 hold kept idle");

    cts_auto_en = 1'b0; tick("R10 auto cts off");
    repeat (2) tick("R10 auto cts off steady");

    @(posedge clk); #2;
    done = 1;
  end

  initial begin
    wait (done);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule